// File: doc/BRIEF.md
# Channel-to-Queue Prioritised Dispatcher

This block sits between a channel service stage and four transfer engines. Each request names a channel number. A packed table of per-channel queue numbers selects one of four event queues for that request, and the request is stored in that queue's FIFO. Queue n always feeds transfer engine n. When several queues hold work, a programmable 3-bit priority per queue decides which one drives the shared outbound channel bus in a given cycle. A lower value means a more urgent queue. Queues that share a priority value are served in order of queue number, lowest first.

Software programs the table and the priorities through a write-only register port. Word k of the table holds the queue choice for channels 8k to 8k+7. One more word holds the four priority fields. The request input stalls through `req_ready` whenever its target FIFO is full, so no request is ever lost. Once a queue has offered an entry to its engine, it keeps offering that entry until the engine accepts it.

Top module: `chq_dispatch`

## Requirements
- R1: Configuration address k (0 to 7) holds the queue fields for channels 8k to 8k+7. Channel 8k+i uses bits [4i+3:4i] of that word. A write takes effect for requests presented in later cycles. A request presented in the same cycle as the write uses the old value.
- R2: After reset, every channel routes to queue 0, all four priority fields are 0, every queue is empty, `eng_valid` is 0 and `req_ready` is 1.
- R3: Only bits [1:0] of a channel's 4-bit field select its queue (0 to 3). Bits [3:2] have no effect on routing.
- R4: An entry stored in queue n is offered only on `eng_valid[n]`, and its channel number appears on `eng_chan`. At most one bit of `eng_valid` is high in any cycle.
- R5: Configuration address 8 holds the priorities: queue q uses bits [4q+2:4q]. When no queue is stalled, the non-empty queue with the lowest priority value is offered. On a tie, the lower queue number wins.
- R6: Each queue holds 16 entries. `req_ready` is low exactly when the target queue of `req_chan` is full. A request is stored only when `req_valid` and `req_ready` are both high.
- R7: Each queue delivers its entries in arrival order, even after the table entry of a channel that already has entries queued is rewritten.
- R8: If `eng_valid[n]` is high and `eng_ready[n]` is low, the next cycle offers the same queue with the same `eng_chan`, whatever the priorities or other arrivals.
- R9: An accepted request can be offered no earlier than the cycle after it is accepted. There is no same-cycle bypass from `req_chan` to `eng_chan`.
- R10: Writes to configuration addresses 9 to 15 change neither routing nor priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address (0-7 queue table, 8 priorities) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Target queue has space |
| req_chan | input | 6 | Channel number of the request |
| eng_valid | output | 4 | Per-engine offer; bit n belongs to engine n |
| eng_ready | input | 4 | Per-engine acceptance |
| eng_chan | output | 6 | Channel number of the offered entry |

## Verification
The outputs `req_ready`, `eng_valid` and `eng_chan` are combinational functions of the current inputs and of the state left by the previous rising edge. A request accepted at an edge becomes visible on the engine side in the following cycle, and a configuration write changes routing or priority from the cycle after its edge. The bench drives inputs on the falling edge and samples all three outputs 1 ns later, still before the next rising edge. It then advances its own queue, lock and table model as of that rising edge, so each comparison sees exactly the register updates that precede it. The sweeps cover every channel under three table layouts, 64 priority combinations with frequent ties, remapping while entries are queued, and a long random mix of stalls and writes.

// File: rtl/chq_pkg.sv
package chq_pkg;

  // Bits in one channel field of a queue-table word.
  localparam int FIELD_W = 4;
  // Channels packed in one 32-bit table word.
  localparam int SLOTS_PER_WORD = 8;

  // Extract the 4-bit field for slot 'slot' from a table word.
  function automatic logic [FIELD_W-1:0] field_of(input logic [31:0] word,
                                                  input logic [2:0]  slot);
    return word[{slot, 2'b00} +: FIELD_W];
  endfunction

  // Priority field of queue 'q' in the priority word: bits [4q+2:4q].
  function automatic logic [2:0] prio_field(input logic [31:0] word,
                                            input int          q);
    return word[q*FIELD_W +: 3];
  endfunction

  // Onehot decode of a small index.
  function automatic logic [3:0] onehot4(input logic [1:0] idx);
    return 4'b0001 << idx;
  endfunction

endpackage

// File: rtl/chq_cfg_regs.sv
module chq_cfg_regs
  import chq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int NUM_Q  = 4,
  parameter int PRIO_W = 3,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int Q_W    = $clog2(NUM_Q),
  localparam int WORDS  = NUM_CH / SLOTS_PER_WORD,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int ADDR_W = $clog2(WORDS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  input  logic [CH_W-1:0]           lookup_chan,
  output logic [Q_W-1:0]            lookup_q,
  output logic [NUM_Q*PRIO_W-1:0]   prio_flat
);

  localparam logic [ADDR_W-1:0] PRIO_ADDR = ADDR_W'(WORDS);

  logic [31:0] map_q [WORDS];
  logic [31:0] prio_word_q;

  // Queue-table words, one register per word.
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[k] <= '0;
      else if (we && addr == ADDR_W'(k))
        map_q[k] <= wdata;
    end
  end

  // Priority word; other addresses fall through with no effect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prio_word_q <= '0;
    else if (we && addr == PRIO_ADDR)
      prio_word_q <= wdata;
  end

  // Table lookup for the presented channel.
  logic [WIDX_W-1:0]   word_idx;
  logic [2:0]          slot_idx;
  logic [FIELD_W-1:0]  chan_field;

  always_comb begin
    word_idx   = lookup_chan[CH_W-1:3];
    slot_idx   = lookup_chan[2:0];
    chan_field = field_of(map_q[word_idx], slot_idx);
    lookup_q   = chan_field[Q_W-1:0];
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_prio
    assign prio_flat[q*PRIO_W +: PRIO_W] = PRIO_W'(prio_field(prio_word_q, q));
  end

endmodule

// File: rtl/chq_fifo.sv
module chq_fifo #(
  parameter int WIDTH = 6,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push)
      mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push)
        wr_ptr <= ptr_next(wr_ptr);
      if (pop)
        rd_ptr <= ptr_next(rd_ptr);
      if (push && !pop)
        cnt_q <= cnt_q + 1'b1;
      else if (pop && !push)
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/chq_arbiter.sv
module chq_arbiter #(
  parameter int NUM_Q  = 4,
  parameter int PRIO_W = 3,
  localparam int Q_W = $clog2(NUM_Q)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_Q-1:0]        nonempty,
  input  logic [NUM_Q*PRIO_W-1:0] prio_flat,
  input  logic [NUM_Q-1:0]        eng_ready,
  output logic [NUM_Q-1:0]        grant,
  output logic [Q_W-1:0]          grant_idx,
  output logic [NUM_Q-1:0]        pop
);

  logic             lock_on;
  logic [Q_W-1:0]   lock_idx;
  logic             pick_any;
  logic [Q_W-1:0]   pick_idx;
  logic [PRIO_W-1:0] best;
  logic             sel_any;
  logic             accepted;

  // Lowest priority value wins; scanning upward with strict compare
  // keeps the lower queue number on ties.
  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    best     = '1;
    for (int q = 0; q < NUM_Q; q++) begin
      if (nonempty[q] && (!pick_any || prio_flat[q*PRIO_W +: PRIO_W] < best)) begin
        pick_any = 1'b1;
        pick_idx = Q_W'(q);
        best     = prio_flat[q*PRIO_W +: PRIO_W];
      end
    end
  end

  // A stalled offer stays with its queue until accepted.
  assign sel_any   = lock_on || pick_any;
  assign grant_idx = lock_on ? lock_idx : pick_idx;
  assign grant     = sel_any ? (NUM_Q'(1) << grant_idx) : '0;
  assign accepted  = sel_any && eng_ready[grant_idx];
  assign pop       = accepted ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_on  <= 1'b0;
      lock_idx <= '0;
    end else if (sel_any && !eng_ready[grant_idx]) begin
      lock_on  <= 1'b1;
      lock_idx <= grant_idx;
    end else begin
      lock_on  <= 1'b0;
    end
  end

endmodule

// File: rtl/chq_dispatch.sv
module chq_dispatch
  import chq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 3,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int Q_W    = $clog2(NUM_Q),
  localparam int ADDR_W = $clog2(NUM_CH / SLOTS_PER_WORD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  output logic [NUM_Q-1:0]  eng_valid,
  input  logic [NUM_Q-1:0]  eng_ready,
  output logic [CH_W-1:0]   eng_chan
);

  // Named internal events, observed by the bound checker.
  logic [Q_W-1:0]          tgt_q;
  logic [NUM_Q*PRIO_W-1:0] prio_flat;
  logic [NUM_Q-1:0]        push_vec;
  logic [NUM_Q-1:0]        pop_vec;
  logic [NUM_Q-1:0]        full_vec;
  logic [NUM_Q-1:0]        empty_vec;
  logic [CH_W-1:0]         head [NUM_Q];
  logic [Q_W-1:0]          grant_idx;
  logic                    req_fire;

  chq_cfg_regs #(
    .NUM_CH (NUM_CH),
    .NUM_Q  (NUM_Q),
    .PRIO_W (PRIO_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .lookup_chan (req_chan),
    .lookup_q    (tgt_q),
    .prio_flat   (prio_flat)
  );

  assign req_ready = !full_vec[tgt_q];
  assign req_fire  = req_valid && req_ready;
  assign push_vec  = req_fire ? (NUM_Q'(1) << tgt_q) : '0;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    chq_fifo #(
      .WIDTH (CH_W),
      .DEPTH (DEPTH)
    ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_vec[q]),
      .din   (req_chan),
      .pop   (pop_vec[q]),
      .dout  (head[q]),
      .full  (full_vec[q]),
      .empty (empty_vec[q])
    );
  end

  chq_arbiter #(
    .NUM_Q  (NUM_Q),
    .PRIO_W (PRIO_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nonempty  (~empty_vec),
    .prio_flat (prio_flat),
    .eng_ready (eng_ready),
    .grant     (eng_valid),
    .grant_idx (grant_idx),
    .pop       (pop_vec)
  );

  assign eng_chan = head[grant_idx];

endmodule

// File: rtl/chq_dispatch_chk.sv
module chq_dispatch_chk #(
  parameter int NUM_Q = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [NUM_Q-1:0] eng_valid,
  input logic [NUM_Q-1:0] eng_ready,
  input logic [5:0]       eng_chan,
  input logic [NUM_Q-1:0] push_vec,
  input logic [NUM_Q-1:0] pop_vec,
  input logic [NUM_Q-1:0] full_vec,
  input logic [NUM_Q-1:0] empty_vec
);

  a_r4_single_offer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_valid));

  a_r4_offer_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid & empty_vec) == '0);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vec & full_vec) == '0);

  a_r6_stall_means_full: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (full_vec != '0));

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_vec & empty_vec) == '0);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_valid & ~eng_ready) != '0) |=> ($stable(eng_valid) && $stable(eng_chan)));

  a_r9_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (&empty_vec) |-> (eng_valid == '0));

endmodule

bind chq_dispatch chq_dispatch_chk #(.NUM_Q(NUM_Q)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .eng_valid (eng_valid),
  .eng_ready (eng_ready),
  .eng_chan  (eng_chan),
  .push_vec  (push_vec),
  .pop_vec   (pop_vec),
  .full_vec  (full_vec),
  .empty_vec (empty_vec)
);

// File: tb/chq_dispatch_test.sv
`timescale 1ns/1ps
module chq_dispatch_test;
  localparam int NCH = 64;
  localparam int NQ = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_chan = '0;
  logic [3:0]  eng_valid;
  logic [3:0]  eng_ready = '0;
  logic [5:0]  eng_chan;

  chq_dispatch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_chan(eng_chan)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mmap [NCH];
  int mprio [NQ];
  int mq [NQ][$];
  bit mlock = 1'b0;
  int mlock_q = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_winner();
    int best = -1;
    if (mlock) return mlock_q;
    for (int q = 0; q < NQ; q++)
      if (mq[q].size() > 0 && (best < 0 || mprio[q] < mprio[best])) best = q;
    return best;
  endfunction

  // One clock cycle: drive at the falling edge, compare 1 ns later,
  // then advance the model to the state after the next rising edge.
  task automatic cycle(input bit we, input int addr, input int data,
                       input bit v, input int ch, input logic [3:0] rdy,
                       input string tag);
    int tq, w, expv;
    bit exp_ready;
    @(negedge clk);
    cfg_we = we; cfg_addr = 4'(addr); cfg_wdata = data;
    req_valid = v; req_chan = 6'(ch); eng_ready = rdy;
    #1;
    tq = mmap[ch];
    w = exp_winner();
    exp_ready = (mq[tq].size() < DEPTH);
    if (v) check(req_ready == exp_ready, {tag, " R6 ready"}, int'(req_ready), int'(exp_ready));
    expv = (w < 0) ? 0 : (1 << w);
    check(int'(eng_valid) == expv, {tag, mlock ? " R8 held valid" : " R5 valid"},
          int'(eng_valid), expv);
    if (w >= 0) check(int'(eng_chan) == mq[w][0], {tag, " R4 chan"}, int'(eng_chan), mq[w][0]);
    if (w >= 0) begin
      if (rdy[w]) begin void'(mq[w].pop_front()); mlock = 1'b0; end
      else begin mlock = 1'b1; mlock_q = w; end
    end else mlock = 1'b0;
    if (v && exp_ready) mq[tq].push_back(ch);
    if (we) begin
      if (addr < 8) for (int i = 0; i < 8; i++) mmap[addr*8+i] = (data >> (4*i)) & 3;
      else if (addr == 8) for (int q = 0; q < NQ; q++) mprio[q] = (data >> (4*q)) & 7;
    end
  endtask

  task automatic idle(input int n, input logic [3:0] rdy, input string tag);
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, rdy, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d expected fewer cycles", 150000);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) mmap[c] = 0;
    for (int q = 0; q < NQ; q++) mprio[q] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R2: reset state at the ports
    check(eng_valid == 4'b0, "R2 reset valid", int'(eng_valid), 0);
    check(req_ready == 1'b1, "R2 reset ready", int'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;

    // R2 default routing to queue 0, R6 fill to 16 then backpressure
    for (int c = 0; c < 20; c++) cycle(0, 0, 0, 1, c, 4'b0000, "R2 default");
    idle(20, 4'b1111, "R7 drain");

    // R9: a lone request is not offered in its own cycle
    cycle(0, 0, 0, 1, 7, 4'b1111, "R9 latency");
    idle(2, 4'b1111, "R9 latency");

    // R1/R3: table layout with garbage in the upper field bits
    for (int k = 0; k < 8; k++) begin
      int d = 0;
      for (int i = 0; i < 8; i++) d |= ((((i + k) & 3) | (((i*3 + k) & 3) << 2)) << (4*i));
      cycle(1, k, d, 0, 0, 4'b0000, "R1 write");
    end
    for (int c = 0; c < NCH; c++) cycle(0, 0, 0, 1, c, 4'($urandom_range(0, 15)), "R1 R3 route");
    idle(80, 4'b1111, "R1 R3 drain");

    // R5: priority sweep with frequent ties
    for (int p = 0; p < 64; p++) begin
      int d = 0;
      int pick [NQ];
      for (int q = 0; q < NQ; q++) d |= (((p >> q) & 3) * ((q & 1) + 1) & 7) << (4*q);
      cycle(1, 8, d, 0, 0, 4'b0000, "R5 write");
      for (int q = 0; q < NQ; q++) begin
        pick[q] = 0;
        for (int c = NCH - 1; c >= 0; c--) if (mmap[c] == q) pick[q] = c;
      end
      for (int q = 0; q < NQ; q++)
        for (int j = 0; j < 2; j++) cycle(0, 0, 0, 1, pick[q], 4'b0000, "R5 fill");
      idle(10, 4'b1111, "R5 order");
    end

    // R7: remap channels that still have queued entries
    for (int c = 8; c < 16; c++) cycle(0, 0, 0, 1, c, 4'b0000, "R7 before");
    cycle(1, 1, 32'h0123_3210, 0, 0, 4'b0000, "R7 remap");
    for (int c = 15; c >= 8; c--) cycle(0, 0, 0, 1, c, 4'b0000, "R7 after");
    for (int i = 0; i < 30; i++) cycle(0, 0, 0, 0, 0, 4'($urandom_range(0, 15)), "R7 drain");
    idle(20, 4'b1111, "R7 drain");

    // R10: unused addresses leave routing and priorities unchanged
    for (int a = 9; a < 16; a++) cycle(1, a, 32'hFFFF_FFFF, 0, 0, 4'b1111, "R10 write");
    for (int c = 0; c < NCH; c++) cycle(0, 0, 0, 1, c, 4'b0000, "R10 route");
    idle(80, 4'b1111, "R10 drain");

    // R8/R9 random mix of stalls, traffic and rewrites
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 31) == 0);
      cycle(we, $urandom_range(0, 8), $urandom(), $urandom_range(0, 1),
            $urandom_range(0, NCH - 1), 4'($urandom_range(0, 15)), "R8 R9 random");
    end
    idle(80, 4'b1111, "R8 drain");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule